// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block sequences the calibration of an oversampling converter. Software writes a 3-bit calibration code. The block then counts conversion-complete ticks, which arrive once per output-rate period, through one or two calibration phases. It marks each phase as zero-scale or full-scale, and as taken from the external input or from the internal reference. When the calibration phases are over, the block returns the code it reports to 000. This tells software that the calibration work has finished. It does not mean that a usable result exists.

After the code clears, the block waits for more conversion ticks so that a normal conversion can finish. It then counts a fixed pipeline delay in master-clock cycles and only then raises its data-ready flag. In background mode the code stays set. Internal zero-scale phases and normal conversions take turns, and data-ready rises at the end of each pair. A sync/hold input freezes all progress, so that coefficient storage elsewhere can be read or written safely.

Top module: `calSequencer`

## Requirements
- R1: After reset, modeOut is 000 and dataReady, calZero, calFull and calSystem are all low.
- R2: Codes 001 (internal zero then internal full-scale) and 100 (input zero then internal full-scale) take 2*PHASE_TICKS ticks before modeOut reads 000. calZero is high for the first PHASE_TICKS ticks and calFull for the rest. For code 100, calSystem is high only in its zero phase.
- R3: Codes 010 (zero-scale from the input) and 011 (full-scale from the input) take PHASE_TICKS ticks before modeOut reads 000. calSystem is high throughout, with calZero for 010 and calFull for 011.
- R4: Codes 110 (internal zero-scale) and 111 (internal full-scale) take PHASE_TICKS ticks before modeOut reads 000. calZero is high for 110, calFull is high for 111, and calSystem stays low.
- R5: After modeOut clears, dataReady rises once further ticks have been counted and then exactly PIPE_DELAY more clock cycles have passed. The number of further ticks is SYS_SETTLE_TICKS (default 1) for 010 and 011, and SETTLE_TICKS (default 3) for 001, 100, 110 and 111.
- R6: In code 101, modeOut stays 101. dataReady rises, with no pipeline delay, in the cycle after every 2*PHASE_TICKS-th tick. calZero is high during the first PHASE_TICKS ticks of each group.
- R7: While syncHold is high, ticks are not counted and the pipeline-delay count does not advance.
- R8: Writing a nonzero code (modeWr high) restarts the sequence from its first phase, loads modeOut with the code and clears dataReady.
- R9: A dataRead pulse clears dataReady. If dataReady is being set in the same cycle, the set takes effect.
- R10: Writing code 000 stops any sequence. modeOut reads 000, the phase flags drop, and no dataReady follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWr | input | 1 | Strobe that loads modeIn |
| modeIn | input | 3 | Calibration code to load |
| convTick | input | 1 | One-cycle pulse per output-rate period |
| syncHold | input | 1 | High freezes the sequence |
| dataRead | input | 1 | Pulse when the result is read |
| modeOut | output | 3 | Current code, cleared when calibration ends |
| dataReady | output | 1 | A valid new result is available |
| calZero | output | 1 | A zero-scale phase is active |
| calFull | output | 1 | A full-scale phase is active |
| calSystem | output | 1 | The active phase uses the external input |

## Verification
Every calibration code except background is run through a full sequence, one code after another. The bench checks the phase flags before each tick and modeOut after each tick. This separates the three groups by the tick on which the code clears, by their settle lengths and by the flags they raise. The pipeline delay is checked cycle by cycle, so an off-by-one in either counter is caught.

Further runs hold syncHold in the middle of the tick phase and again in the middle of the delay, and restart one calibration with a different code. Another run stops a calibration with code 000. The background run covers two full groups and lands a read on the same cycle as a set, which tells set priority apart from clear priority.

// File: rtl/calPkg.sv
package calPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL,
    ST_SETTLE,
    ST_PIPE,
    ST_BG
  } seqStateT;

  typedef struct packed {
    logic tickClr;
    logic tickInc;
    logic pipeClr;
    logic pipeInc;
  } dpStrobeT;

  localparam logic [2:0] CODE_NORMAL  = 3'b000;
  localparam logic [2:0] CODE_SELF2   = 3'b001;
  localparam logic [2:0] CODE_SYSZERO = 3'b010;
  localparam logic [2:0] CODE_SYSFULL = 3'b011;
  localparam logic [2:0] CODE_OFFS2   = 3'b100;
  localparam logic [2:0] CODE_BACKGND = 3'b101;
  localparam logic [2:0] CODE_INTZERO = 3'b110;
  localparam logic [2:0] CODE_INTFULL = 3'b111;

endpackage

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
#(
  parameter int TICK_W     = 4,
  parameter int PIPE_DELAY = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  output logic [TICK_W-1:0] tickCnt,
  output logic              pipeDone
);

  localparam int PIPE_W = (PIPE_DELAY > 1) ? $clog2(PIPE_DELAY + 1) : 1;
  localparam logic [PIPE_W-1:0] PIPE_LAST = PIPE_W'(PIPE_DELAY - 1);

  logic [PIPE_W-1:0] pipeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.tickClr) begin
      tickCnt <= '0;
    end else if (strobe.tickInc) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeCnt <= '0;
    end else if (strobe.pipeClr) begin
      pipeCnt <= '0;
    end else if (strobe.pipeInc) begin
      pipeCnt <= pipeCnt + 1'b1;
    end
  end

  assign pipeDone = (pipeCnt == PIPE_LAST);

  // R5: the delay counter never runs past its terminal value
  a_r5_pipe_in_range: assert property (@(posedge clk) disable iff (!rstN)
    pipeCnt <= PIPE_LAST);

  // R7: the delay counter moves only when the control asks for it
  a_r7_pipe_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pipeClr && !strobe.pipeInc) |=> $stable(pipeCnt));

endmodule

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
#(
  parameter int TICK_W           = 4,
  parameter int PHASE_TICKS      = 3,
  parameter int SETTLE_TICKS     = 3,
  parameter int SYS_SETTLE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [2:0]        modeIn,
  input  logic              convTick,
  input  logic              syncHold,
  input  logic              dataRead,
  input  logic [TICK_W-1:0] tickCnt,
  input  logic              pipeDone,
  output dpStrobeT          strobe,
  output logic [2:0]        modeOut,
  output logic              dataReady,
  output logic              calZero,
  output logic              calFull,
  output logic              calSystem
);

  localparam logic [TICK_W-1:0] LAST_TWO  = TICK_W'(2 * PHASE_TICKS - 1);
  localparam logic [TICK_W-1:0] LAST_ONE  = TICK_W'(PHASE_TICKS - 1);
  localparam logic [TICK_W-1:0] LAST_SET  = TICK_W'(SETTLE_TICKS - 1);
  localparam logic [TICK_W-1:0] LAST_SYS  = TICK_W'(SYS_SETTLE_TICKS - 1);
  localparam logic [TICK_W-1:0] HALF_MARK = TICK_W'(PHASE_TICKS);

  seqStateT   state;
  logic [2:0] calKind;
  logic       tickEv;
  logic       twoPhase;
  logic       sysSingle;
  logic       firstHalf;
  logic [TICK_W-1:0] lastIdx;
  logic       lastTick;
  logic       setReady;
  logic       startCal;

  always_comb begin
    tickEv    = convTick && !syncHold;
    startCal  = modeWr && (modeIn != CODE_NORMAL);
    twoPhase  = (calKind == CODE_SELF2) || (calKind == CODE_OFFS2);
    sysSingle = (calKind == CODE_SYSZERO) || (calKind == CODE_SYSFULL);
    firstHalf = (tickCnt < HALF_MARK);
    case (state)
      ST_CAL:    lastIdx = twoPhase ? LAST_TWO : LAST_ONE;
      ST_SETTLE: lastIdx = sysSingle ? LAST_SYS : LAST_SET;
      default:   lastIdx = LAST_TWO;
    endcase
    lastTick = (tickCnt == lastIdx);
  end

  always_comb begin
    setReady = 1'b0;
    if (!modeWr) begin
      if (state == ST_PIPE && !syncHold && pipeDone) setReady = 1'b1;
      if (state == ST_BG && tickEv && lastTick)      setReady = 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    if (modeWr) begin
      strobe.tickClr = 1'b1;
      strobe.pipeClr = 1'b1;
    end else begin
      if (state == ST_CAL || state == ST_SETTLE || state == ST_BG) begin
        if (tickEv && lastTick)  strobe.tickClr = 1'b1;
        else if (tickEv)         strobe.tickInc = 1'b1;
      end
      if (state == ST_SETTLE && tickEv && lastTick) strobe.pipeClr = 1'b1;
      if (state == ST_PIPE && !syncHold && !pipeDone) strobe.pipeInc = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      calKind <= CODE_NORMAL;
      modeOut <= CODE_NORMAL;
    end else if (modeWr) begin
      calKind <= modeIn;
      modeOut <= modeIn;
      if (modeIn == CODE_NORMAL)       state <= ST_IDLE;
      else if (modeIn == CODE_BACKGND) state <= ST_BG;
      else                             state <= ST_CAL;
    end else begin
      case (state)
        ST_CAL: if (tickEv && lastTick) begin
          modeOut <= CODE_NORMAL;
          state   <= ST_SETTLE;
        end
        ST_SETTLE: if (tickEv && lastTick) state <= ST_PIPE;
        ST_PIPE:   if (setReady) state <= ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dataReady <= 1'b0;
    else if (startCal)  dataReady <= 1'b0;
    else if (setReady)  dataReady <= 1'b1;
    else if (dataRead)  dataReady <= 1'b0;
  end

  always_comb begin
    calZero   = 1'b0;
    calFull   = 1'b0;
    calSystem = 1'b0;
    if (state == ST_CAL) begin
      if (twoPhase) begin
        calZero   = firstHalf;
        calFull   = !firstHalf;
        calSystem = (calKind == CODE_OFFS2) && firstHalf;
      end else begin
        calZero   = (calKind == CODE_SYSZERO) || (calKind == CODE_INTZERO);
        calFull   = (calKind == CODE_SYSFULL) || (calKind == CODE_INTFULL);
        calSystem = sysSingle;
      end
    end else if (state == ST_BG) begin
      calZero = firstHalf;
    end
  end

  // R6: background mode keeps its code until a new write
  a_r6_bg_keeps_code: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BG && !modeWr) |=> (modeOut == CODE_BACKGND));

  // R8: a nonzero write always leaves data-ready low
  a_r8_start_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && modeIn != CODE_NORMAL) |=> !dataReady);

  // R7: under hold the tick count is frozen
  a_r7_hold_freezes_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (syncHold && !modeWr) |=> $stable(tickCnt));

  // R4: the code drops to 000 on its own only on a counted tick
  a_r4_clear_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != CODE_NORMAL && !modeWr) |=>
      (modeOut == $past(modeOut)) || ($past(convTick) && !$past(syncHold)));

  // R9: a read with no set pending leaves data-ready low
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !modeWr && state != ST_PIPE && state != ST_BG) |=> !dataReady);

  // R2: never both phase kinds at once
  a_r2_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({calZero, calFull}));

endmodule

// File: rtl/calSequencer.sv
module calSequencer
  import calPkg::*;
#(
  parameter int PHASE_TICKS      = 3,
  parameter int SETTLE_TICKS     = 3,
  parameter int SYS_SETTLE_TICKS = 1,
  parameter int PIPE_DELAY       = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWr,
  input  logic [2:0] modeIn,
  input  logic       convTick,
  input  logic       syncHold,
  input  logic       dataRead,
  output logic [2:0] modeOut,
  output logic       dataReady,
  output logic       calZero,
  output logic       calFull,
  output logic       calSystem
);

  localparam int MAX_TICKS = (2 * PHASE_TICKS > SETTLE_TICKS) ? 2 * PHASE_TICKS : SETTLE_TICKS;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);

  dpStrobeT          strobe;
  logic [TICK_W-1:0] tickCnt;
  logic              pipeDone;

  calCtrl #(
    .TICK_W          (TICK_W),
    .PHASE_TICKS     (PHASE_TICKS),
    .SETTLE_TICKS    (SETTLE_TICKS),
    .SYS_SETTLE_TICKS(SYS_SETTLE_TICKS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeWr   (modeWr),
    .modeIn   (modeIn),
    .convTick (convTick),
    .syncHold (syncHold),
    .dataRead (dataRead),
    .tickCnt  (tickCnt),
    .pipeDone (pipeDone),
    .strobe   (strobe),
    .modeOut  (modeOut),
    .dataReady(dataReady),
    .calZero  (calZero),
    .calFull  (calFull),
    .calSystem(calSystem)
  );

  calDatapath #(
    .TICK_W    (TICK_W),
    .PIPE_DELAY(PIPE_DELAY)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .tickCnt (tickCnt),
    .pipeDone(pipeDone)
  );

endmodule

// File: tb/test_calSequencer.sv
`timescale 1ns/1ps
module test_calSequencer;

  localparam int PH = 3;
  localparam int DLY = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWr = 1'b0;
  logic [2:0] modeIn = 3'b000;
  logic convTick = 1'b0;
  logic syncHold = 1'b0;
  logic dataRead = 1'b0;
  logic [2:0] modeOut;
  logic dataReady, calZero, calFull, calSystem;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  calSequencer #(.PHASE_TICKS(PH), .PIPE_DELAY(DLY)) i_calSequencer (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeIn(modeIn),
    .convTick(convTick), .syncHold(syncHold), .dataRead(dataRead),
    .modeOut(modeOut), .dataReady(dataReady), .calZero(calZero),
    .calFull(calFull), .calSystem(calSystem)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeMode(input logic [2:0] m);
    @(negedge clk); modeWr = 1'b1; modeIn = m;
    @(negedge clk); modeWr = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk); convTick = 1'b1;
    @(negedge clk); convTick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sample data-ready over the delay window; starts right after the releasing edge
  task automatic watchPipe(input string req);
    for (int i = 0; i <= DLY; i++) begin
      check(req, int'(dataReady), (i >= DLY) ? 1 : 0);
      if (i < DLY) @(negedge clk);
    end
  endtask

  task automatic runCal(input logic [2:0] m);
    int calN, setN;
    bit two;
    two  = (m == 3'b001) || (m == 3'b100);
    calN = two ? 2 * PH : PH;
    setN = (m == 3'b010 || m == 3'b011) ? 1 : 3;
    writeMode(m);
    check("R8", int'(modeOut), int'(m));
    check("R8", int'(dataReady), 0);
    for (int k = 0; k < calN; k++) begin
      if (two) begin
        check("R2", int'(calZero), (k < PH) ? 1 : 0);
        check("R2", int'(calFull), (k < PH) ? 0 : 1);
        check("R2", int'(calSystem), (m == 3'b100 && k < PH) ? 1 : 0);
      end else if (m == 3'b010 || m == 3'b011) begin
        check("R3", int'(calZero), (m == 3'b010) ? 1 : 0);
        check("R3", int'(calFull), (m == 3'b011) ? 1 : 0);
        check("R3", int'(calSystem), 1);
      end else begin
        check("R4", int'(calZero), (m == 3'b110) ? 1 : 0);
        check("R4", int'(calFull), (m == 3'b111) ? 1 : 0);
        check("R4", int'(calSystem), 0);
      end
      doTick();
      check(two ? "R2" : "R4", int'(modeOut), (k + 1 >= calN) ? 0 : int'(m));
      idle(2);
    end
    check("R4", int'(calZero | calFull | calSystem), 0);
    for (int k = 0; k < setN; k++) begin
      if (k > 0) idle(2);
      doTick();
      check("R5", int'(dataReady), 0);
      check("R5", int'(modeOut), 0);
    end
    watchPipe("R5");
    @(negedge clk); dataRead = 1'b1;
    @(negedge clk); dataRead = 1'b0;
    check("R9", int'(dataReady), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    check("R1", int'(modeOut), 0);
    check("R1", int'(dataReady), 0);
    check("R1", int'({calZero, calFull, calSystem}), 0);
    rstN = 1'b1;
    idle(2);
    check("R1", int'(modeOut), 0);

    // sweep every calibration code
    runCal(3'b001);
    runCal(3'b100);
    runCal(3'b010);
    runCal(3'b011);
    runCal(3'b110);
    runCal(3'b111);

    // R7: hold during ticks and during the delay
    writeMode(3'b010);
    doTick(); idle(2);
    syncHold = 1'b1;
    for (int k = 0; k < 5; k++) begin doTick(); idle(1); end
    check("R7", int'(modeOut), 2);
    syncHold = 1'b0;
    doTick(); idle(2);
    check("R7", int'(modeOut), 2);
    doTick();
    check("R7", int'(modeOut), 0);
    idle(2);
    doTick();
    syncHold = 1'b1;
    idle(60);
    check("R7", int'(dataReady), 0);
    syncHold = 1'b0;
    watchPipe("R7");

    // R8: restart with another code
    writeMode(3'b001);
    for (int k = 0; k < 4; k++) begin doTick(); idle(2); end
    check("R8", int'(calFull), 1);
    writeMode(3'b110);
    check("R8", int'(modeOut), 6);
    check("R8", int'(calZero), 1);
    check("R8", int'(calFull), 0);
    for (int k = 0; k < PH; k++) begin doTick(); idle(2); end
    check("R8", int'(modeOut), 0);
    for (int k = 0; k < 3; k++) begin
      if (k > 0) idle(2);
      doTick();
    end
    watchPipe("R8");
    writeMode(3'b011);
    check("R8", int'(dataReady), 0);

    // R10: stop with 000
    doTick(); idle(2);
    writeMode(3'b000);
    check("R10", int'(modeOut), 0);
    check("R10", int'(calZero | calFull | calSystem), 0);
    for (int k = 0; k < 10; k++) begin doTick(); idle(2); end
    idle(DLY + 5);
    check("R10", int'(dataReady), 0);

    // R6: background mode, two groups
    writeMode(3'b101);
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 2 * PH; k++) begin
        check("R6", int'(calZero), (k < PH) ? 1 : 0);
        doTick();
        check("R6", int'(modeOut), 5);
        check("R6", int'(dataReady), (k == 2 * PH - 1) ? 1 : 0);
        if (k == 2 * PH - 1) begin
          dataRead = 1'b1; @(negedge clk); dataRead = 1'b0;
          check("R9", int'(dataReady), 0);
        end
        idle(2);
      end
    end
    // R9: read coincides with a set
    for (int k = 0; k < 2 * PH - 1; k++) begin doTick(); idle(2); end
    @(negedge clk); convTick = 1'b1; dataRead = 1'b1;
    @(negedge clk); convTick = 1'b0; dataRead = 1'b0;
    check("R9", int'(dataReady), 1);
    check("R6", int'(modeOut), 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule